// File: doc/BRIEF.md
# Interrupt Status Register With Summaries

This block is the interrupt status word of a network controller. Event pulses from the transmit and receive engines, the link monitor, the general-purpose timer, the wake-up logic and the bus interface each set a sticky bit. The bit stays set until host software clears it. Three small read-only fields sit in the same word. They show the cause of a fatal bus error and the states of the transmit and receive processes. Two summary bits gather the event bits into a normal group and an abnormal group.

The host reaches the block over a simple register bus with one address bit. Address 0 is the status word. Writing a 1 to an event bit there clears it. Address 1 is a companion enable mask. One registered interrupt line is raised when an enabled summary is set. While a fatal bus error is pending, a bus-disable output tells the bus interface to stop all access.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, the status word reads 0x00000000, the mask reads 0, and irq and bus_off are 0. The three state fields read the stopped code 000.
- R2: A pulse on ev_pulse[i] sets status bit i on the next clock edge, for every i in 0..14 except 12. The bit then stays set until it is cleared.
- R3: A write to address 0 clears each event bit whose wdata bit is 1. It leaves every event bit whose wdata bit is 0 unchanged.
- R4: If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: ev_pulse[12] (link fail) sets bit 12 only while lf_port_sel=0, lf_enable=1 and lf_ctrl=0. In any other case the pulse is ignored.
- R6: Bit 27 (link change) sets when link_ok differs from its value in the previous cycle. The value held before the first clock after reset counts as 0.
- R7: A wake_ev pulse sets bit 28 only while pwr_down=1. Otherwise it is ignored.
- R8: Bit 16 is the OR of bits 0, 2, 6 and 28. Bit 15 is the OR of bits 1, 3, 5, 7, 8, 9, 10, 11, 13 and 27. Bits 4, 12 and 14 feed neither summary. Writes to bits 15 and 16 have no effect.
- R9: Bits 25:23 show err_code, bits 22:20 show tx_state and bits 19:17 show rx_state. Each field shows its input as sampled at the previous clock edge, and writes do not change it. Bits 26 and 31:29 read 0.
- R10: bus_off is 1 exactly while status bit 13 is set.
- R11: The mask at address 1 keeps bits 16 (normal enable) and 15 (abnormal enable). Its other bits read 0. irq equals (bit16 AND enable16) OR (bit15 AND enable15), taken from the register state one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| ev_pulse | input | 15 | Event pulses, index equals status bit |
| link_ok | input | 1 | Live 100 Mb/s link pass status |
| wake_ev | input | 1 | Wake-up event pulse |
| pwr_down | input | 1 | Device is in power-down mode |
| lf_port_sel | input | 1 | Link-fail qualifier, must be 0 |
| lf_enable | input | 1 | Link-fail qualifier, must be 1 |
| lf_ctrl | input | 1 | Link-fail qualifier, must be 0 |
| err_code | input | 3 | Fatal bus error cause |
| tx_state | input | 3 | Transmit process state code |
| rx_state | input | 3 | Receive process state code |
| bus_off | output | 1 | Stop all bus access |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the same bit, in the same cycle, as a new event. Only the kept bit shows that the collision happened. A close second is link fail, which needs all three qualifiers in one exact combination at the moment of the pulse. A directed sequence sets up each of these on purpose. The random phase then draws each qualifier and pwr_down with even odds and clears with random masks, so both situations come up again many times.

// File: rtl/irq_status_reg.sv
module irq_status_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [14:0] ev_pulse,
  input  logic        link_ok,
  input  logic        wake_ev,
  input  logic        pwr_down,
  input  logic        lf_port_sel,
  input  logic        lf_enable,
  input  logic        lf_ctrl,
  input  logic [2:0]  err_code,
  input  logic [2:0]  tx_state,
  input  logic [2:0]  rx_state,
  output logic        bus_off,
  output logic        irq
);

  localparam logic [31:0] EV_BITS = (32'h1 << 28) | (32'h1 << 27) | 32'h0000_7FFF;

  logic [31:0] ev_q;
  logic [8:0]  fld_q;
  logic        link_q;
  logic [1:0]  ena_q;
  logic [31:0] set_vec, clr_vec, word;
  logic        lf_qual, sum_n, sum_a;

  assign lf_qual = !lf_port_sel && lf_enable && !lf_ctrl;

  always_comb begin
    set_vec        = '0;
    set_vec[14:0]  = ev_pulse;
    set_vec[12]    = ev_pulse[12] && lf_qual;
    set_vec[27]    = link_ok ^ link_q;
    set_vec[28]    = wake_ev && pwr_down;
  end

  assign clr_vec = (reg_wr && !reg_addr) ? reg_wdata : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      fld_q  <= '0;
      link_q <= 1'b0;
      ena_q  <= '0;
    end else begin
      ev_q   <= ((ev_q & ~clr_vec) | set_vec) & EV_BITS;
      fld_q  <= {err_code, tx_state, rx_state};
      link_q <= link_ok;
      if (reg_wr && reg_addr) ena_q <= {reg_wdata[16], reg_wdata[15]};
    end
  end

  assign sum_n = ev_q[0] | ev_q[2] | ev_q[6] | ev_q[28];
  assign sum_a = ev_q[1] | ev_q[3] | ev_q[5] | ev_q[7] | ev_q[8] | ev_q[9]
               | ev_q[10] | ev_q[11] | ev_q[13] | ev_q[27];

  always_comb begin
    word        = ev_q;
    word[16]    = sum_n;
    word[15]    = sum_a;
    word[25:17] = fld_q;
  end

  assign reg_rdata = reg_addr ? {15'h0, ena_q[1], ena_q[0], 15'h0} : word;
  assign bus_off   = ev_q[13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (sum_n && ena_q[1]) || (sum_a && ena_q[0]);
  end

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && !reg_addr) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pulse[0] |=> reg_rdata[0] || reg_addr);

  p_lf_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_q[12] && !lf_qual) |=> !ev_q[12]);

  p_wake_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_q[28] && !pwr_down) |=> !ev_q[28]);

  p_busoff_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> $past(ev_pulse[13]));

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == 2'b00) |=> !irq);

endmodule

// File: tb/test_irq_status_reg.sv
module test_irq_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [14:0] ev_pulse = '0;
  logic        link_ok = 1'b0, wake_ev = 1'b0, pwr_down = 1'b0;
  logic        lf_port_sel = 1'b0, lf_enable = 1'b0, lf_ctrl = 1'b0;
  logic [2:0]  err_code = '0, tx_state = '0, rx_state = '0;
  logic        bus_off, irq;

  irq_status_reg i_irq_status_reg (.*);

  always #10 clk = ~clk;

  localparam logic [31:0] EVM  = 32'h1800_7FFF;
  localparam logic [31:0] NRM  = 32'h1000_0045;
  localparam logic [31:0] ABN  = 32'h0800_2FAA;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_st = '0;
  logic [8:0]  m_fld = '0;
  logic        m_prev = 1'b0, m_irq = 1'b0;
  logic [1:0]  m_ena = '0;

  function automatic logic [31:0] exp_word(logic [31:0] st, logic [8:0] fld);
    logic [31:0] w;
    w = st & EVM;
    w[16] = |(st & NRM);
    w[15] = |(st & ABN);
    w[25:17] = fld;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    logic [31:0] set;
    logic [31:0] clr;
    m_irq = (|(m_st & NRM) && m_ena[1]) || (|(m_st & ABN) && m_ena[0]);
    set = {17'h0, ev_pulse};
    set[12] = ev_pulse[12] && !lf_port_sel && lf_enable && !lf_ctrl;
    set[27] = link_ok ^ m_prev;
    set[28] = wake_ev && pwr_down;
    clr = (reg_wr && !reg_addr) ? reg_wdata : 32'h0;
    m_st = ((m_st & ~clr) | set) & EVM;
    if (reg_wr && reg_addr) m_ena = {reg_wdata[16], reg_wdata[15]};
    m_fld = {err_code, tx_state, rx_state};
    m_prev = link_ok;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R8 R9 rdata"}, reg_rdata,
        reg_addr ? {15'h0, m_ena, 15'h0} : exp_word(m_st, m_fld));
    chk({tag, " R10 bus_off"}, {31'h0, bus_off}, {31'h0, m_st[13]});
    chk({tag, " R11 irq"}, {31'h0, irq}, {31'h0, m_irq});
  endtask

  task automatic idle();
    reg_wr = 0; ev_pulse = '0; wake_ev = 0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 reset irq", {30'h0, irq, bus_off}, 32'h0);
    rst_n = 1'b1;
    chk("R1 reset status", reg_rdata, 32'h0);
    reg_addr = 1; #1;
    chk("R1 reset mask", reg_rdata, 32'h0);
    reg_addr = 0;

    ev_pulse = 15'h0041; cyc("R2 set bits 0 and 6");
    idle(); cyc("R2 bits stay set");
    reg_wr = 1; reg_wdata = 32'h0000_0040; cyc("R3 clear bit 6 only");
    reg_wdata = 32'hFFFF_FFFF; ev_pulse = 15'h0001; cyc("R4 set beats clear");
    chk("R4 bit 0 kept", {31'h0, reg_rdata[0]}, 32'h1);
    idle(); reg_wr = 1; reg_wdata = 32'h0001_8000; cyc("R8 summary bits not writable");
    idle(); lf_enable = 1; lf_port_sel = 1; ev_pulse[12] = 1; cyc("R5 port_sel blocks");
    chk("R5 bit12 clear", {31'h0, reg_rdata[12]}, 32'h0);
    lf_port_sel = 0; lf_ctrl = 1; cyc("R5 ctrl blocks");
    lf_ctrl = 0; cyc("R5 qualified sets");
    chk("R5 bit12 set", {31'h0, reg_rdata[12]}, 32'h1);
    idle(); link_ok = 1; cyc("R6 link up");
    chk("R6 bit27", {31'h0, reg_rdata[27]}, 32'h1);
    wake_ev = 1; cyc("R7 wake while awake");
    pwr_down = 1; cyc("R7 wake in power-down");
    chk("R7 bit28", {31'h0, reg_rdata[28]}, 32'h1);
    idle(); err_code = 3'd5; tx_state = 3'd3; rx_state = 3'd6;
    reg_wr = 1; reg_wdata = 32'h03FE_0000; cyc("R9 fields ignore write");
    idle(); ev_pulse[13] = 1; cyc("R10 fatal error");
    idle(); reg_addr = 1; reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; cyc("R11 mask write");
    idle(); cyc("R11 irq follows");

    for (int k = 0; k < 4000; k++) begin
      ev_pulse    = 15'($urandom & $urandom & $urandom);
      wake_ev     = ($urandom % 8) == 0;
      pwr_down    = $urandom % 2;
      link_ok     = ($urandom % 16) == 0 ? ~link_ok : link_ok;
      lf_port_sel = $urandom % 2;
      lf_enable   = $urandom % 2;
      lf_ctrl     = $urandom % 2;
      err_code    = 3'($urandom);
      tx_state    = 3'($urandom);
      rx_state    = 3'($urandom);
      reg_wr      = ($urandom % 3) == 0;
      reg_addr    = ($urandom % 5) == 0;
      reg_wdata   = $urandom & $urandom;
      cyc("R2 R3 R4 R5 R6 R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule